// File: doc/BRIEF.md
# Interrupt Line Enable and Pending Controller

This block keeps an enable bit and a pending bit for each of up to 32 external interrupt lines and presents them to software through a small 32-bit register bus. Each of the two state vectors is reached through a pair of addresses. One address sets bits and the other clears them, and only the bits written as 1 take effect. Software can therefore switch a single line on or off, or raise or drop its pending state, with one store and no read-modify-write.

Hardware requests are sampled on every clock edge. A line that is high at an edge marks itself pending, so a one-cycle pulse is enough. Software can also force a line pending. Among the lines that are both enabled and pending, the lowest-numbered one is offered to the core as a request with an index, unless a global mask input is high. When the core acknowledges an index, that line's pending bit drops at the same edge.

Top module: `irqc_top`

## Requirements
- R1: After reset, every enable bit and every pending bit is 0, and `req_valid` is 0.
- R2: A write to byte address 0x100 sets the enable bits written as 1 and leaves the others unchanged. A read of 0x100 returns the enable vector, with bit k standing for line k.
- R3: A write to 0x180 clears the enable bits written as 1 and leaves the others unchanged.
- R4: A write to 0x200 sets the pending bits written as 1, which forces those lines to request. A read of 0x200 returns the pending vector.
- R5: A write to 0x280 clears the pending bits written as 1 and leaves the others unchanged.
- R6: A read of 0x180 returns the same value as a read of 0x100, and a read of 0x280 returns the same value as a read of 0x200. A read of any other address returns 0. An address matches only when its two low bits are 0.
- R7: A line that is high at a clock edge sets its pending bit at that edge, so a one-cycle pulse is enough. The bit then stays set after the line falls.
- R8: When a high hardware line and a write to 0x280 clearing the same bit fall in the same cycle, the bit ends up set.
- R9: `req_valid` is 1 exactly when some line is both enabled and pending and `mask_all` is 0. `req_index` then gives the lowest-numbered such line.
- R10: `ack_valid` with `ack_index` = k clears pending bit k at that edge. This clear overrides a hardware or software set in the same cycle. If line k is still high in the next cycle, the bit is set again at the following edge.
- R11: `mask_all` changes no enable or pending bit. Pending state is kept while the mask is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 32 | Hardware request lines |
| mask_all | input | 1 | Global mask that holds off the request output |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_index | input | 5 | Line being acknowledged |
| req_valid | output | 1 | A line is enabled, pending and not masked |
| req_index | output | 5 | Lowest-numbered enabled pending line |

## Verification
Three updates of the pending vector can land on the same bit in one cycle: a hardware line, a software set or clear, and a core acknowledge. The bench forces the collision of a high line with a pending-clear write on the same bit, and the collision of an acknowledge with a still-high level line. It judges both by reading the pending vector in the next cycles. Long random runs also drive sparse line patterns together with random alias writes and acknowledges. Each cycle, the read data and the request outputs are compared against a bench model that applies the precedence order from the requirements: hardware set over software clear, and acknowledge over all.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned MAX_LINES = 32;

    typedef logic [MAX_LINES-1:0] line_vec_t;

    // byte offsets of the split set/clear aliases
    localparam logic [11:0] OFF_EN_SET = 12'h100;
    localparam logic [11:0] OFF_EN_CLR = 12'h180;
    localparam logic [11:0] OFF_PD_SET = 12'h200;
    localparam logic [11:0] OFF_PD_CLR = 12'h280;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR
    } reg_sel_e;

    typedef struct packed {
        line_vec_t en;
        line_vec_t pend;
    } irqc_state_t;

    typedef struct packed {
        line_vec_t en_set;
        line_vec_t en_clr;
        line_vec_t pd_set;
        line_vec_t pd_clr;
    } irqc_wr_t;

endpackage

// File: rtl/irqc_bus_dec.sv
module irqc_bus_dec
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  line_vec_t         en_q,
    input  line_vec_t         pend_q,
    output irqc_wr_t          wr_d,
    output logic [31:0]       rdata_d
);

    localparam line_vec_t LINE_MASK =
        (N_LINES >= MAX_LINES) ? '1 : line_vec_t'((64'd1 << N_LINES) - 64'd1);

    reg_sel_e  sel_d;
    line_vec_t wmask_d;

    always_comb begin
        sel_d = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr == ADDR_W'(OFF_EN_SET))      sel_d = SEL_EN_SET;
            else if (bus_addr == ADDR_W'(OFF_EN_CLR)) sel_d = SEL_EN_CLR;
            else if (bus_addr == ADDR_W'(OFF_PD_SET)) sel_d = SEL_PD_SET;
            else if (bus_addr == ADDR_W'(OFF_PD_CLR)) sel_d = SEL_PD_CLR;
        end
    end

    always_comb begin
        wmask_d = bus_wr ? (bus_wdata & LINE_MASK) : '0;
        wr_d    = '0;
        rdata_d = '0;
        unique case (sel_d)
            SEL_EN_SET: begin wr_d.en_set = wmask_d; rdata_d = en_q;   end
            SEL_EN_CLR: begin wr_d.en_clr = wmask_d; rdata_d = en_q;   end
            SEL_PD_SET: begin wr_d.pd_set = wmask_d; rdata_d = pend_q; end
            SEL_PD_CLR: begin wr_d.pd_clr = wmask_d; rdata_d = pend_q; end
            default:    rdata_d = '0;
        endcase
    end

endmodule

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  irqc_wr_t           wr_d,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_index,
    output line_vec_t          en_q,
    output line_vec_t          pend_q
);

    localparam line_vec_t LINE_MASK =
        (N_LINES >= MAX_LINES) ? '1 : line_vec_t'((64'd1 << N_LINES) - 64'd1);

    irqc_state_t st_d, st_q;
    line_vec_t   hw_d;
    line_vec_t   ack_d;

    generate
        if (N_LINES >= MAX_LINES) begin : g_full
            assign hw_d = line_vec_t'(irq_lines[MAX_LINES-1:0]);
        end else begin : g_part
            assign hw_d = {{(MAX_LINES-N_LINES){1'b0}}, irq_lines};
        end
    endgenerate

    always_comb begin
        ack_d = '0;
        if (ack_valid && (32'(ack_index) < N_LINES)) begin
            ack_d[ack_index] = 1'b1;
        end
        st_d.en   = ((st_q.en | wr_d.en_set) & ~wr_d.en_clr) & LINE_MASK;
        // precedence: sw clear < hw set < acknowledge
        st_d.pend = ((((st_q.pend | wr_d.pd_set) & ~wr_d.pd_clr) | hw_d) & ~ack_d)
                    & LINE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  line_vec_t        en_q,
    input  line_vec_t        pend_q,
    input  logic             mask_all,
    output logic             req_valid,
    output logic [IDX_W-1:0] req_index
);

    logic [N_LINES-1:0] live_d;

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_live
            assign live_d[g] = en_q[g] & pend_q[g];
        end
    endgenerate

    always_comb begin
        req_index = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (live_d[i]) req_index = IDX_W'(i);
        end
        req_valid = (|live_d) & ~mask_all;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               mask_all,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_index,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_index
);

    irqc_wr_t  wr_d;
    line_vec_t en_q;
    line_vec_t pend_q;

    irqc_bus_dec #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .wr_d      (wr_d),
        .rdata_d   (bus_rdata)
    );

    irqc_state #(.N_LINES(N_LINES)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_d      (wr_d),
        .ack_valid (ack_valid),
        .ack_index (ack_index),
        .en_q      (en_q),
        .pend_q    (pend_q)
    );

    irqc_pick #(.N_LINES(N_LINES)) u_pick (
        .en_q      (en_q),
        .pend_q    (pend_q),
        .mask_all  (mask_all),
        .req_valid (req_valid),
        .req_index (req_index)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [31:0]        bus_wdata,
    input logic [N_LINES-1:0] irq_lines,
    input logic               mask_all,
    input logic               ack_valid,
    input logic [IDX_W-1:0]   ack_index,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_index,
    input line_vec_t          en_q,
    input line_vec_t          pend_q
);

    line_vec_t act_c;
    line_vec_t below_c;
    line_vec_t hw_keep_c;
    logic      wr_en_set_c;

    always_comb begin
        act_c       = en_q & pend_q;
        below_c     = (line_vec_t'(1) << req_index) - line_vec_t'(1);
        hw_keep_c   = line_vec_t'(irq_lines);
        if (ack_valid) hw_keep_c[ack_index] = 1'b0;
        wr_en_set_c = bus_wr && (bus_addr == ADDR_W'(OFF_EN_SET));
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0) && (pend_q == '0));

    assert_set_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_set_c |=> ((en_q & ~$past(bus_wdata)) == ($past(en_q) & ~$past(bus_wdata))));

    assert_line_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(hw_keep_c)) == $past(hw_keep_c)));

    assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_all |-> !req_valid);

    assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (act_c[req_index] && ((act_c & below_c) == '0)));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !pend_q[$past(ack_index)]);

    assert_mask_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all && !bus_wr && !ack_valid && (irq_lines == '0))
        |=> ((pend_q == $past(pend_q)) && (en_q == $past(en_q))));

endmodule

bind irqc_top irqc_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_lines (irq_lines),
    .mask_all  (mask_all),
    .ack_valid (ack_valid),
    .ack_index (ack_index),
    .req_valid (req_valid),
    .req_index (req_index),
    .en_q      (en_q),
    .pend_q    (pend_q)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        mask_all = 1'b0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_index = '0;
    logic        req_valid;
    logic [4:0]  req_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] en_m = '0;
    logic [31:0] pd_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u_irqc_top (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq_lines (irq_lines), .mask_all (mask_all),
        .ack_valid (ack_valid), .ack_index (ack_index),
        .req_valid (req_valid), .req_index (req_index)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h100, 12'h180: return en_m;
            12'h200, 12'h280: return pd_m;
            default:          return 32'h0;
        endcase
    endfunction

    function automatic int exp_idx(input logic [31:0] act);
        for (int i = 0; i < 32; i++) if (act[i]) return i;
        return 0;
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        case (a)
            12'h100: return "R2";
            12'h200: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare outputs, model the edge
    task automatic cyc(input string tag, input logic [11:0] a, input logic w,
                       input logic [31:0] d, input logic [31:0] l,
                       input logic av, input logic [4:0] ai, input logic m,
                       output logic [31:0] rd);
        logic [31:0] ackm;
        logic [31:0] act;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; irq_lines = l;
        ack_valid = av; ack_index = ai; mask_all = m;
        #1;
        rd = bus_rdata;
        check((tag == "") ? read_tag(a) : tag, bus_rdata, exp_read(a));
        act = en_m & pd_m;
        check((tag == "") ? "R9" : tag, {31'b0, req_valid}, {31'b0, (act != 0) && !m});
        if ((act != 0) && !m)
            check((tag == "") ? "R9" : tag, {27'b0, req_index}, exp_idx(act));
        @(posedge clk);
        ackm = av ? (32'd1 << ai) : 32'd0;
        if (w) begin
            case (a)
                12'h100: en_m = en_m | d;
                12'h180: en_m = en_m & ~d;
                12'h200: pd_m = pd_m | d;
                12'h280: pd_m = pd_m & ~d;
                default: ;
            endcase
        end
        pd_m = (pd_m | l) & ~ackm;
    endtask

    task automatic rd_only(input string tag, input logic [11:0] a, input logic [31:0] l,
                           input logic m, output logic [31:0] rd);
        cyc(tag, a, 1'b0, 32'h0, l, 1'b0, 5'd0, m, rd);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before the run ended");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(SEED));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: state after reset
        rd_only("R1", 12'h100, 0, 0, r); check("R1", r, 0);
        rd_only("R1", 12'h200, 0, 0, r); check("R1", r, 0);

        // R2: set alias, zero bits ignored
        cyc("R2", 12'h100, 1, 32'h5, 0, 0, 0, 0, r);
        cyc("R2", 12'h100, 1, 32'h0, 0, 0, 0, 0, r);
        rd_only("R2", 12'h100, 0, 0, r); check("R2", r, 32'h5);

        // R3 and R6: clear alias, read back through clear address
        cyc("R3", 12'h180, 1, 32'h1, 0, 0, 0, 0, r);
        rd_only("R3", 12'h180, 0, 0, r); check("R3", r, 32'h4);

        // R4: software forces line 2
        cyc("R4", 12'h200, 1, 32'h4, 0, 0, 0, 0, r);
        rd_only("R4", 12'h200, 0, 0, r); check("R4", r, 32'h4);
        check("R4", {31'b0, req_valid}, 1); check("R4", {27'b0, req_index}, 2);

        // R10: acknowledge clears
        cyc("R10", 12'h200, 0, 0, 0, 1, 5'd2, 0, r);
        rd_only("R10", 12'h200, 0, 0, r); check("R10", r, 0);
        check("R10", {31'b0, req_valid}, 0);

        // R5: pending clear hands the request to the next line
        cyc("R5", 12'h100, 1, 32'h30, 0, 0, 0, 0, r);
        cyc("R5", 12'h200, 1, 32'h30, 0, 0, 0, 0, r);
        rd_only("R5", 12'h200, 0, 0, r); check("R5", {27'b0, req_index}, 4);
        cyc("R5", 12'h280, 1, 32'h10, 0, 0, 0, 0, r);
        rd_only("R5", 12'h280, 0, 0, r); check("R5", r, 32'h20);
        check("R5", {27'b0, req_index}, 5);

        // R7: one-cycle pulse on line 7 stays pending
        cyc("R7", 12'h200, 0, 0, 32'h80, 0, 0, 0, r);
        rd_only("R7", 12'h200, 0, 0, r);
        rd_only("R7", 12'h200, 0, 0, r); check("R7", r & 32'h80, 32'h80);

        // R8: hw line 9 against software clear of bit 9
        cyc("R8", 12'h280, 1, 32'h200, 32'h200, 0, 0, 0, r);
        rd_only("R8", 12'h200, 0, 0, r); check("R8", r & 32'h200, 32'h200);

        // R10: ack while level still high, re-pend one cycle later
        cyc("R10", 12'h180, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, r);
        cyc("R10", 12'h100, 1, 32'h200, 32'h200, 1, 5'd9, 0, r);
        rd_only("R10", 12'h200, 32'h200, 0, r); check("R10", r & 32'h200, 0);
        rd_only("R10", 12'h200, 0, 0, r); check("R10", r & 32'h200, 32'h200);

        // R11: mask holds off request but keeps state
        rd_only("R11", 12'h200, 0, 1, r); check("R11", {31'b0, req_valid}, 0);
        rd_only("R11", 12'h200, 0, 1, r); check("R11", r & 32'h200, 32'h200);
        rd_only("R11", 12'h100, 0, 0, r); check("R11", r, 32'h200);

        // R6: unmapped and misaligned addresses read zero
        rd_only("R6", 12'h300, 0, 0, r); check("R6", r, 0);
        rd_only("R6", 12'h101, 0, 0, r); check("R6", r, 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            logic [31:0] l;
            logic        av;
            logic [4:0]  ai;
            case ($urandom_range(0, 5))
                0: a = 12'h100; 1: a = 12'h180; 2: a = 12'h200;
                3: a = 12'h280; 4: a = 12'h300; default: a = 12'h104;
            endcase
            l  = $urandom & $urandom & $urandom & $urandom;
            av = ($urandom_range(0, 9) < 3);
            ai = ($urandom_range(0, 1) != 0 && req_valid) ? req_index : 5'($urandom);
            cyc("", a, $urandom_range(0, 1) != 0, $urandom & $urandom, l, av, ai,
                $urandom_range(0, 9) < 2, r);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule